// File: doc/BRIEF.md
# Dual-Mode Pulse Width Timer

An 8-bit down-counter shared by two functions. As an interval timer it counts down from a programmed start value on every count-clock tick and, when it wraps from 1 to 0, either restarts from that value (periodic) or stops (single shot). As a width meter it waits for a chosen start edge on an input pin, counts down from all ones, and on the chosen stop edge freezes, latches the number of elapsed ticks and finishes.

Software reaches the block through a small register-write port and a combinational read port. There are two control registers, a start-value register and a result register. A timer-output bit flips on every 1-to-0 wrap. Software can count these flips to extend a measurement beyond 256 ticks. One interrupt flag reports both an interval wrap and a finished measurement. The count clock comes from a free-running prescaler that divides the system clock by 2, 8 or 32.

Top module: `pwt_top`

## Requirements
- R1: After reset every register reads 0: run control (address 0), mode control (address 1), start value (address 2), and the `tout` and `irq` outputs are low.
- R2: With the mode bit (address 1 bit 7) at 0 and the single-shot bit (bit 6) at 0, the output bit flips every V count-clock ticks, where V is the start value, and V=0 means 256 ticks.
- R3: With bit 6 at 1 in interval mode, the counter stops after the first wrap. The result register (address 3) then reads 0 and the run bit (address 0 bit 0) reads 0.
- R4: The output bit (`tout`, also address 1 bit 5) flips only when the counter passes from 0x01 to 0x00 on a tick, in either mode.
- R5: The flag (address 0 bit 1, mirrored on `irq`) is set by an interval wrap or a finished measurement. Writing 0 to it clears it. Writing 1 leaves it unchanged.
- R6: Clock select (address 1 bits 3:2) gives ticks at clk/2 for 00, clk/8 for 01 and clk/32 for 10. The reserved code 11 gives no ticks, so the counter holds.
- R7: Writes to address 1 are ignored while the run bit is 1.
- R8: Address 1 bit 4 always reads 0. Bit 5 reflects the output bit and cannot be written.
- R9: With bit 7 at 1, edge select (address 1 bits 1:0) sets the measured span. 00 runs from rising to falling, 01 from rising to rising, 10 from falling to falling and 11 from falling to rising. Address 3 then reads the tick count modulo 256.
- R10: The stop edge clears the run bit and sets the flag.
- R11: A measurement longer than 255 ticks flips the output bit once per wrap, and the captured value is the count modulo 256.
- R12: The single-shot bit has no effect on a measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| pulse_in | input | 1 | Measured input, already synchronous |
| tout | output | 1 | Wrap toggle output |
| irq | output | 1 | Interrupt flag |

## Verification
The hardest case to reach is a measurement that runs past a counter wrap. The bench needs a pulse of several hundred clocks. It must then check both the flipped output bit and the captured value, which equals the count modulo 256. Prescaler phase is unknown from the ports. The bench therefore places every pin edge on a falling clock edge and chooses widths that are multiples of the divider, which makes the tick count exact. Interval periods are taken as the clock gaps between consecutive output flips, so the phase of the first flip does not matter.

// File: rtl/pwt_pkg.sv
package pwt_pkg;

    localparam int DW = 8;
    localparam int AW = 2;

    localparam logic [AW-1:0] A_CTRL1  = 2'd0;
    localparam logic [AW-1:0] A_CTRL2  = 2'd1;
    localparam logic [AW-1:0] A_RELOAD = 2'd2;
    localparam logic [AW-1:0] A_COUNT  = 2'd3;

    localparam int B_RUN  = 0;
    localparam int B_FLAG = 1;

    typedef enum logic [1:0] {
        CLK_DIV_A = 2'b00,
        CLK_DIV_B = 2'b01,
        CLK_DIV_C = 2'b10,
        CLK_OFF   = 2'b11
    } clk_sel_e;

    typedef enum logic [1:0] {
        EDG_HIGH_W   = 2'b00,
        EDG_CYC_RISE = 2'b01,
        EDG_CYC_FALL = 2'b10,
        EDG_LOW_W    = 2'b11
    } edge_sel_e;

    typedef struct packed {
        logic      meas;
        logic      one_shot;
        clk_sel_e  clk_sel;
        edge_sel_e edge_sel;
    } cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_INTERVAL,
        ST_ARMED,
        ST_MEASURE
    } state_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edges_t;

    function automatic logic start_hit(edge_sel_e s, edges_t e);
        return (s == EDG_HIGH_W || s == EDG_CYC_RISE) ? e.rise : e.fall;
    endfunction

    function automatic logic stop_hit(edge_sel_e s, edges_t e);
        return (s == EDG_HIGH_W || s == EDG_CYC_FALL) ? e.fall : e.rise;
    endfunction

    function automatic logic [DW-1:0] cfg_to_byte(cfg_t c, logic t);
        return {c.meas, c.one_shot, t, 1'b0, c.clk_sel, c.edge_sel};
    endfunction

    function automatic cfg_t byte_to_cfg(logic [DW-1:0] b);
        cfg_t c;
        c.meas     = b[7];
        c.one_shot = b[6];
        c.clk_sel  = clk_sel_e'(b[3:2]);
        c.edge_sel = edge_sel_e'(b[1:0]);
        return c;
    endfunction

endpackage

// File: rtl/pwt_prescaler.sv
module pwt_prescaler
    import pwt_pkg::*;
#(
    parameter int PRE_W = 5,
    parameter int SH_A  = 1,
    parameter int SH_B  = 3,
    parameter int SH_C  = 5
) (
    input  logic     clk,
    input  logic     rst,
    input  clk_sel_e sel,
    output logic     tick
);
    localparam int NTAP = 3;
    localparam int SH [NTAP] = '{SH_A, SH_B, SH_C};

    logic [PRE_W-1:0] div_cnt;
    logic [NTAP-1:0]  tap;

    always_ff @(posedge clk) begin
        if (rst) div_cnt <= '0;
        else     div_cnt <= div_cnt + 1'b1;
    end

    for (genvar g = 0; g < NTAP; g++) begin : g_tap
        assign tap[g] = &div_cnt[SH[g]-1:0];
    end

    always_comb begin
        unique case (sel)
            CLK_DIV_A: tick = tap[0];
            CLK_DIV_B: tick = tap[1];
            CLK_DIV_C: tick = tap[2];
            default:   tick = 1'b0;
        endcase
    end

    // R6: reserved select never advances the counter
    a_r6_reserved_no_tick: assert property (@(posedge clk) disable iff (rst)
        (sel == CLK_OFF) |-> !tick);

endmodule

// File: rtl/pwt_edge_det.sv
module pwt_edge_det
    import pwt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   pin,
    output edges_t edges
);
    logic pin_q;

    always_ff @(posedge clk) begin
        if (rst) pin_q <= 1'b0;
        else     pin_q <= pin;
    end

    assign edges.rise = pin & ~pin_q;
    assign edges.fall = ~pin & pin_q;

endmodule

// File: rtl/pwt_core.sv
module pwt_core
    import pwt_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  cfg_t          cfg,
    input  logic [DW-1:0] reload,
    input  logic          tick,
    input  edges_t        edges,
    input  logic          go,
    input  logic          halt,
    output state_e        state,
    output logic [DW-1:0] cnt,
    output logic [DW-1:0] capture,
    output logic          tout,
    output logic          uflow_evt,
    output logic          done_evt
);
    state_e        state_n;
    logic [DW-1:0] cnt_n, cap_n, cnt_step;
    logic          tout_n;
    logic          at_one, start_now, stop_now;

    assign at_one    = (cnt == DW'(1));
    assign cnt_step  = tick ? cnt - 1'b1 : cnt;
    assign start_now = start_hit(cfg.edge_sel, edges);
    assign stop_now  = stop_hit(cfg.edge_sel, edges);

    always_comb begin
        state_n   = state;
        cnt_n     = cnt;
        cap_n     = capture;
        tout_n    = tout;
        uflow_evt = 1'b0;
        done_evt  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (go) begin
                    if (cfg.meas) begin
                        state_n = ST_ARMED;
                    end else begin
                        state_n = ST_INTERVAL;
                        cnt_n   = reload;
                    end
                end
            end
            ST_INTERVAL: begin
                if (halt) begin
                    state_n = ST_IDLE;
                end else if (tick) begin
                    if (at_one) begin
                        uflow_evt = 1'b1;
                        tout_n    = ~tout;
                        if (cfg.one_shot) begin
                            cnt_n   = '0;
                            state_n = ST_IDLE;
                        end else begin
                            cnt_n = reload;
                        end
                    end else begin
                        cnt_n = cnt - 1'b1;
                    end
                end
            end
            ST_ARMED: begin
                if (halt) begin
                    state_n = ST_IDLE;
                end else if (start_now) begin
                    cnt_n   = '1;
                    state_n = ST_MEASURE;
                end
            end
            default: begin
                if (halt) begin
                    state_n = ST_IDLE;
                end else begin
                    cnt_n = cnt_step;
                    if (tick && at_one) tout_n = ~tout;
                    if (stop_now) begin
                        cap_n    = {DW{1'b1}} - cnt_step;
                        done_evt = 1'b1;
                        state_n  = ST_IDLE;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            capture <= '0;
            tout    <= 1'b0;
        end else begin
            state   <= state_n;
            cnt     <= cnt_n;
            capture <= cap_n;
            tout    <= tout_n;
        end
    end

    // R2: periodic mode restarts from the start value after a wrap
    a_r2_restart: assert property (@(posedge clk) disable iff (rst)
        (state == ST_INTERVAL && !halt && tick && at_one && !cfg.one_shot)
        |=> (cnt == $past(reload) && state == ST_INTERVAL));

    // R3: single shot stops at zero after its first wrap
    a_r3_single_stop: assert property (@(posedge clk) disable iff (rst)
        (state == ST_INTERVAL && !halt && tick && at_one && cfg.one_shot)
        |=> (state == ST_IDLE && cnt == '0));

    // R4: the output bit moves only on a 1-to-0 tick while counting
    a_r4_tout_on_wrap: assert property (@(posedge clk) disable iff (rst)
        !((state == ST_INTERVAL || state == ST_MEASURE) && !halt && tick && at_one)
        |=> $stable(tout));

    // R10: a stop edge ends the measurement
    a_r10_stop_ends: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MEASURE && !halt && stop_now) |=> (state == ST_IDLE));

    // R9: an armed meter holds until its start edge
    a_r9_armed_waits: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARMED && !halt && !start_now) |=> (state == ST_ARMED));

endmodule

// File: rtl/pwt_top.sv
module pwt_top
    import pwt_pkg::*;
#(
    parameter int PRE_W = 5,
    parameter int SH_A  = 1,
    parameter int SH_B  = 3,
    parameter int SH_C  = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          pulse_in,
    output logic          tout,
    output logic          irq
);
    cfg_t          cfg;
    logic [DW-1:0] reload;
    logic          flag;
    logic          tick, go, halt, run;
    logic          uflow_evt, done_evt;
    logic [DW-1:0] cnt, capture;
    state_e        state;
    edges_t        edges;
    logic          wr_c1, wr_c2, wr_rl;

    assign wr_c1 = wr_en && (wr_addr == A_CTRL1);
    assign wr_c2 = wr_en && (wr_addr == A_CTRL2);
    assign wr_rl = wr_en && (wr_addr == A_RELOAD);
    assign go    = wr_c1 &&  wr_data[B_RUN];
    assign halt  = wr_c1 && !wr_data[B_RUN];
    assign run   = (state != ST_IDLE);

    pwt_prescaler #(
        .PRE_W(PRE_W), .SH_A(SH_A), .SH_B(SH_B), .SH_C(SH_C)
    ) i_pre (
        .clk(clk), .rst(rst), .sel(cfg.clk_sel), .tick(tick)
    );

    pwt_edge_det i_edge (
        .clk(clk), .rst(rst), .pin(pulse_in), .edges(edges)
    );

    pwt_core i_core (
        .clk(clk), .rst(rst), .cfg(cfg), .reload(reload), .tick(tick),
        .edges(edges), .go(go), .halt(halt), .state(state), .cnt(cnt),
        .capture(capture), .tout(tout), .uflow_evt(uflow_evt),
        .done_evt(done_evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= byte_to_cfg('0);
            reload <= '0;
            flag   <= 1'b0;
        end else begin
            if (wr_c2 && !run) cfg <= byte_to_cfg(wr_data);
            if (wr_rl)         reload <= wr_data;
            if (uflow_evt || done_evt)       flag <= 1'b1;
            else if (wr_c1 && !wr_data[B_FLAG]) flag <= 1'b0;
        end
    end

    always_comb begin
        unique case (rd_addr)
            A_CTRL1:  rd_data = {{(DW-2){1'b0}}, flag, run};
            A_CTRL2:  rd_data = cfg_to_byte(cfg, tout);
            A_RELOAD: rd_data = reload;
            default:  rd_data = cfg.meas ? capture : cnt;
        endcase
    end

    assign irq = flag;

    // R7: mode control is frozen while running
    a_r7_cfg_locked: assert property (@(posedge clk) disable iff (rst)
        run |=> $stable(cfg));

    // R5: any wrap or completion leaves the flag set
    a_r5_flag_set: assert property (@(posedge clk) disable iff (rst)
        (uflow_evt || done_evt) |=> irq);

    // R10: completion also drops the run bit
    a_r10_run_drops: assert property (@(posedge clk) disable iff (rst)
        done_evt |=> !run);

endmodule

// File: tb/test_pwt_top.sv
module test_pwt_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       pulse_in = 1'b0;
    logic       tout;
    logic       irq;

    int errors = 0;
    int checks = 0;
    bit done_run = 0;

    // scoreboard state
    int  exp_q[$];
    bit  mon_en = 0;
    bit  mon_first = 0;
    int  cyc = 0;
    int  last_tgl = 0;
    int  tgl_total = 0;
    logic tout_prev = 1'b0;

    always #10 clk = ~clk;

    pwt_top i_pwt_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pulse_in(pulse_in), .tout(tout), .irq(irq)
    );

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops one expected gap per output flip
    always @(negedge clk) begin
        cyc++;
        if (!rst && tout !== tout_prev) begin
            tgl_total++;
            if (mon_en) begin
                if (mon_first) begin
                    mon_first = 0;
                end else if (exp_q.size() > 0) begin
                    check(cyc - last_tgl, exp_q.pop_front(), "R2/R6 flip gap");
                end else begin
                    check(1, 0, "R4 unexpected flip");
                end
            end
            last_tgl = cyc;
        end
        tout_prev = tout;
    end

    // driver: periodic interval run with n expected gaps
    task automatic run_interval(input int rl, input logic [1:0] cs, input int div, input int n);
        int ticks = (rl == 0) ? 256 : rl;
        wr(2'd2, rl[7:0]);
        wr(2'd1, {4'b0000, cs, 2'b00});
        for (int i = 0; i < n; i++) exp_q.push_back(ticks * div);
        mon_first = 1; mon_en = 1;
        wr(2'd0, 8'h01);
        while (exp_q.size() > 0) @(negedge clk);
        mon_en = 0;
        wr(2'd0, 8'h00);
    endtask

    task automatic measure(input logic [7:0] c2, input int hi, input int lo,
                           input int exp, input string tag);
        logic [7:0] d;
        wr(2'd1, c2);
        wr(2'd0, 8'h01);
        idle(3);
        pulse_in = 1'b1; idle(hi);
        pulse_in = 1'b0; idle(lo);
        pulse_in = 1'b1; idle(hi);
        pulse_in = 1'b0; idle(10);
        rd(2'd3, d);
        check(d, exp, tag);
        rd(2'd0, d);
        check(d, 8'h02, "R10 run cleared flag set");
        wr(2'd0, 8'h00);
    endtask

    initial begin
        logic [7:0] d;
        int t0;
        idle(3);
        rst = 1'b0;
        idle(2);
        // R1 reset state
        rd(2'd0, d); check(d, 0, "R1 ctrl1");
        rd(2'd1, d); check(d, 0, "R1 ctrl2");
        rd(2'd2, d); check(d, 0, "R1 start value");
        check(tout, 0, "R1 tout"); check(irq, 0, "R1 irq");

        // R2 / R6 periodic at each divider, plus start value 0
        run_interval(5, 2'b00, 2, 3);
        run_interval(3, 2'b01, 8, 2);
        run_interval(2, 2'b10, 32, 2);
        run_interval(0, 2'b00, 2, 2);

        // R3 / R5 single shot
        wr(2'd0, 8'h00);
        wr(2'd2, 8'd4);
        wr(2'd1, 8'h40);
        t0 = tgl_total;
        wr(2'd0, 8'h01);
        idle(200);
        check(tgl_total - t0, 1, "R3 R4 one flip only");
        rd(2'd3, d); check(d, 0, "R3 count at zero");
        rd(2'd0, d); check(d, 8'h02, "R3 R5 stopped, flag set");
        check(irq, 1, "R5 irq high");
        wr(2'd0, 8'h02);
        rd(2'd0, d); check(d, 8'h02, "R5 write 1 keeps flag");
        wr(2'd0, 8'h00);
        rd(2'd0, d); check(d, 8'h00, "R5 write 0 clears flag");

        // R7 lock while running, R8 bit 4 / bit 5
        wr(2'd2, 8'd50);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h01);
        wr(2'd1, 8'hC5);
        rd(2'd1, d); check(d & 8'hDF, 8'h00, "R7 ctrl2 unchanged while running");
        wr(2'd0, 8'h00);
        wr(2'd1, 8'hFF);
        rd(2'd1, d); check(d & 8'hDF, 8'hCF, "R8 bit4 reads 0");
        check(d[5], tout, "R8 bit5 is tout");

        // R6 reserved select holds the counter
        wr(2'd1, 8'h0C);
        wr(2'd2, 8'd5);
        wr(2'd0, 8'h01);
        idle(200);
        rd(2'd3, d); check(d, 5, "R6 reserved code holds count");
        wr(2'd0, 8'h00);

        // R9 edge modes, H=40 L=60 clocks at clk/2
        measure(8'h80, 40, 60, 20, "R9 high width");
        measure(8'h81, 40, 60, 50, "R9 rise-to-rise cycle");
        measure(8'h82, 40, 60, 50, "R9 fall-to-fall cycle");
        measure(8'h83, 40, 60, 30, "R9 low width");
        // R12 single-shot bit ignored when measuring
        measure(8'hC0, 40, 60, 20, "R12 single-shot bit ignored");
        // R11 long pulse: 300 ticks -> 44, one flip
        t0 = tgl_total;
        measure(8'h80, 600, 20, 44, "R11 long capture");
        check(tgl_total - t0, 1, "R11 one flip on wrap");

        done_run = 1;
    end

    initial begin
        fork
            begin
                wait (done_run);
            end
            begin
                repeat (150000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=finish");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule